// File: doc/BRIEF.md
# Microstep Position Sequencer

This block tracks where a two-phase stepper sits inside one electrical period. It keeps a 10-bit position (1024 entries per period) and moves it forward or back on every accepted step. The size of each move follows a 4-bit resolution code. From the position it produces two lookup indices into an external current table: one for phase A, and one for phase B that is a quarter period ahead. It also produces an index signal. The table itself and the bridge drive sit outside the block.

Steps come from one of two sources. The first is an external step input with a direction input; both pass through a two-flop synchronizer, and edges are detected on the system clock. The second is an internal generator driven by a signed velocity word. While the velocity word is non-zero, the generator has control and the external step input is ignored. At coarse resolutions the position is placed at the middle of each stride, so the resulting wave stays symmetric about the zero crossings.

Top module: `ustep_sequencer`

## Requirements
- R1: After reset, position_o is 0, phase_a_o is 0, phase_b_o is 256, and index_o is 1 when idx_step_mode_i is 0 or 0 when it is 1.
- R2: With res_code_i = 0 and velocity_i = 0, each accepted external step changes position_o by exactly 1. It moves up when the effective direction is 0 and down when it is 1, wrapping modulo 1024 (stepping down from 0 gives 1023). The change appears no later than the third rising clock edge after the input changes.
- R3: The effective direction of an external step is dir_i XOR dir_inv_i, so dir_inv_i = 1 reverses the sense of dir_i.
- R4: For res_code_i = c with 1 <= c <= 8, a step moves the position to the next (or previous) multiple of 2^c and then adds 2^(c-1). For example, full step (c = 8) visits 128, 384, 640 and 896. With c = 3, starting from 0, forward steps give 12 and then 20.
- R5: Codes 9 to 15 behave exactly like code 8 (full step).
- R6: phase_a_o equals position_o, and phase_b_o equals (position_o + 256) modulo 1024.
- R7: When dual_edge_i = 1, both the 0-to-1 and the 1-to-0 transitions of step_i are steps. When dual_edge_i = 0, only 0-to-1 transitions are steps.
- R8: While velocity_i (two's complement) is non-zero, steps come only from the internal generator. The generator adds |velocity_i| into a 24-bit accumulator every clock and steps on each carry, so 2^22 gives one step every 4 clocks. A negative value means reverse, XORed with dir_inv_i. External steps are ignored. Once velocity_i is 0 the accumulator is cleared; any generator step already issued is still applied.
- R9: When idx_step_mode_i = 0, index_o is 1 while position_o >> c is 0 (the first slot of the period at the effective code c). When idx_step_mode_i = 1, index_o toggles on every accepted step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | External step input (asynchronous) |
| dir_i | input | 1 | External direction input (asynchronous) |
| dir_inv_i | input | 1 | Direction invert configuration |
| dual_edge_i | input | 1 | Count both step edges |
| res_code_i | input | 4 | Resolution code, stride 2^code |
| velocity_i | input | 24 | Signed velocity word for the internal generator |
| idx_step_mode_i | input | 1 | 1: index toggles on steps, 0: first-slot flag |
| position_o | output | 10 | Position within the electrical period |
| phase_a_o | output | 10 | Phase A table index |
| phase_b_o | output | 10 | Phase B table index |
| index_o | output | 1 | Index output |

## Verification
Two paths can land on the same clock edge. One is the generator's last queued step, issued just before the velocity word returns to zero. The other is the source selector handing control back to the external input, which may carry a synchronized edge of its own. The bench provokes this in two ways: it toggles step_i in the middle of a velocity window, and it ends the window on an edge where a generator carry is pending. It judges the outcome by the exact final position. The position must move by precisely the number of generator carries in the window, in the direction of the velocity's sign, and no external edge may be counted.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  // one accepted step and its direction (1 = towards lower positions)
  typedef struct packed {
    logic valid;
    logic rev;
  } step_req_t;
endpackage

// File: rtl/ustep_step_sync.sv
module ustep_step_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic dir_i,
  input  logic dual_edge_i,
  output logic edge_o,
  output logic dir_o
);
  // bit STAGES holds the previous synchronized sample for edge detection
  logic [STAGES:0]   step_ff_q, step_ff_d;
  logic [STAGES-1:0] dir_ff_q,  dir_ff_d;

  always_comb begin
    step_ff_d = {step_ff_q[STAGES-1:0], step_i};
    dir_ff_d  = {dir_ff_q[STAGES-2:0], dir_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_ff_q <= '0;
      dir_ff_q  <= '0;
    end else begin
      step_ff_q <= step_ff_d;
      dir_ff_q  <= dir_ff_d;
    end
  end

  always_comb begin
    if (dual_edge_i) edge_o = step_ff_q[STAGES-1] ^ step_ff_q[STAGES];
    else             edge_o = step_ff_q[STAGES-1] & ~step_ff_q[STAGES];
    dir_o = dir_ff_q[STAGES-1];
  end

  // R7
  single_edge_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && !dual_edge_i) |-> (step_ff_q[STAGES-1] && !step_ff_q[STAGES]));
endmodule

// File: rtl/ustep_vel_gen.sv
module ustep_vel_gen #(
  parameter int VEL_W = 24,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEL_W-1:0] vel_i,
  output logic             active_o,
  output logic             step_o,
  output logic             rev_o
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             step_q, step_d;
  logic             rev_q, rev_d;
  logic [VEL_W-1:0] mag;
  logic [SUM_W-1:0] sum;
  logic             active;

  always_comb begin
    active = |vel_i;
    mag    = vel_i[VEL_W-1] ? (~vel_i + 1'b1) : vel_i;
    sum    = {1'b0, acc_q} + SUM_W'(mag);
    acc_d  = active ? sum[ACC_W-1:0] : '0;
    step_d = active & sum[ACC_W];
    rev_d  = step_d ? vel_i[VEL_W-1] : rev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      step_q <= 1'b0;
      rev_q  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      step_q <= step_d;
      rev_q  <= rev_d;
    end
  end

  assign active_o = active;
  assign step_o   = step_q;
  assign rev_o    = rev_q;

  // R8
  idle_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vel_i == '0) |=> !step_o);
endmodule

// File: rtl/ustep_pos_core.sv
module ustep_pos_core
  import ustep_pkg::*;
#(
  parameter int POS_W = 10,
  parameter int RES_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_req_t        req_i,
  input  logic [RES_W-1:0] res_code_i,
  input  logic             idx_step_mode_i,
  output logic [POS_W-1:0] pos_o,
  output logic             index_o
);
  localparam int               MAX_CODE = POS_W - 2;
  localparam logic [POS_W-1:0] ONE      = POS_W'(1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             tgl_q, tgl_d;
  logic [RES_W-1:0] eff_code;
  logic [POS_W-1:0] stride, half, base, moved;

  always_comb begin
    eff_code = (res_code_i > RES_W'(MAX_CODE)) ? RES_W'(MAX_CODE) : res_code_i;
    stride   = ONE << eff_code;
    half     = stride >> 1;
    base     = pos_q & ~(stride - ONE);
    moved    = req_i.rev ? (base - stride) : (base + stride);
    pos_d    = req_i.valid ? (moved | half) : pos_q;
    tgl_d    = tgl_q ^ req_i.valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      tgl_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      tgl_q <= tgl_d;
    end
  end

  assign pos_o   = pos_q;
  assign index_o = idx_step_mode_i ? tgl_q : ((pos_q >> eff_code) == '0);

  // R2
  hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i.valid |=> $stable(pos_q));
  // R4
  mid_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i.valid |=> ((pos_q & ($past(stride) - ONE)) == ($past(stride) >> 1)));
  // R2
  fine_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i.valid && !req_i.rev && res_code_i == '0) |=> (pos_q == $past(pos_q) + ONE));
  // R9
  monitor_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i.valid |=> (tgl_q != $past(tgl_q)));
endmodule

// File: rtl/ustep_sequencer.sv
module ustep_sequencer
  import ustep_pkg::*;
#(
  parameter int POS_W     = 10,
  parameter int RES_W     = 4,
  parameter int VEL_W     = 24,
  parameter int ACC_W     = 24,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic             dir_inv_i,
  input  logic             dual_edge_i,
  input  logic [RES_W-1:0] res_code_i,
  input  logic [VEL_W-1:0] velocity_i,
  input  logic             idx_step_mode_i,
  output logic [POS_W-1:0] position_o,
  output logic [POS_W-1:0] phase_a_o,
  output logic [POS_W-1:0] phase_b_o,
  output logic             index_o
);
  localparam logic [POS_W-1:0] QUARTER = POS_W'(1) << (POS_W - 2);

  logic      ext_edge, ext_dir;
  logic      gen_active, gen_step, gen_rev;
  step_req_t req;
  logic [POS_W-1:0] pos;

  ustep_step_sync #(.STAGES(SYNC_STGS)) i_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_i),
    .dir_i       (dir_i),
    .dual_edge_i (dual_edge_i),
    .edge_o      (ext_edge),
    .dir_o       (ext_dir)
  );

  ustep_vel_gen #(.VEL_W(VEL_W), .ACC_W(ACC_W)) i_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .vel_i    (velocity_i),
    .active_o (gen_active),
    .step_o   (gen_step),
    .rev_o    (gen_rev)
  );

  // a queued generator step wins over an external edge on the same cycle
  always_comb begin
    req.valid = gen_step | (ext_edge & ~gen_active);
    req.rev   = (gen_step ? gen_rev : ext_dir) ^ dir_inv_i;
  end

  ustep_pos_core #(.POS_W(POS_W), .RES_W(RES_W)) i_core (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_i           (req),
    .res_code_i      (res_code_i),
    .idx_step_mode_i (idx_step_mode_i),
    .pos_o           (pos),
    .index_o         (index_o)
  );

  assign position_o = pos;
  assign phase_a_o  = pos;
  assign phase_b_o  = pos + QUARTER;

  // R8
  ext_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_active && !gen_step) |=> $stable(position_o));
endmodule

// File: tb/test_ustep_sequencer.sv
module test_ustep_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i, dir_i, dir_inv_i, dual_edge_i, idx_step_mode_i;
  logic [3:0]  res_code_i;
  logic [23:0] velocity_i;
  logic [9:0]  position_o, phase_a_o, phase_b_o;
  logic        index_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ustep_sequencer i_ustep_sequencer (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_i(dir_i),
    .dir_inv_i(dir_inv_i), .dual_edge_i(dual_edge_i), .res_code_i(res_code_i),
    .velocity_i(velocity_i), .idx_step_mode_i(idx_step_mode_i),
    .position_o(position_o), .phase_a_o(phase_a_o), .phase_b_o(phase_b_o),
    .index_o(index_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step_i = 0; dir_i = 0; dir_inv_i = 0; dual_edge_i = 0;
    idx_step_mode_i = 0; res_code_i = 0; velocity_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      step_i = 1'b1; repeat (4) @(negedge clk);
      step_i = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(position_o == 0, "R1 position", position_o, 0);
    chk(phase_b_o == 256, "R1 phase_b", phase_b_o, 256);
    chk(index_o == 1, "R1 index", index_o, 1);
    idx_step_mode_i = 1; #1;
    chk(index_o == 0, "R1 index monitor", index_o, 0);
  endtask

  task automatic t_fine();
    do_reset();
    pulse(5);
    chk(position_o == 5, "R2 forward", position_o, 5);
    dir_i = 1; pulse(6);
    chk(position_o == 1023, "R2 reverse wrap", position_o, 1023);
    chk(phase_a_o == 1023, "R6 phase_a", phase_a_o, 1023);
    chk(phase_b_o == 255, "R6 phase_b wrap", phase_b_o, 255);
  endtask

  task automatic t_invert();
    do_reset();
    dir_inv_i = 1; pulse(1);
    chk(position_o == 1023, "R3 inverted fwd", position_o, 1023);
    dir_i = 1; pulse(2);
    chk(position_o == 1, "R3 inverted rev", position_o, 1);
  endtask

  task automatic t_coarse();
    do_reset();
    res_code_i = 8; pulse(1);
    chk(position_o == 384, "R4 full step 1", position_o, 384);
    pulse(2);
    chk(position_o == 896, "R4 full step 3", position_o, 896);
    chk(phase_b_o == 128, "R6 phase_b at 896", phase_b_o, 128);
    pulse(1);
    chk(position_o == 128, "R4 full step wrap", position_o, 128);
    do_reset();
    res_code_i = 3; pulse(2);
    chk(position_o == 20, "R4 code3 fwd", position_o, 20);
    dir_i = 1; pulse(1);
    chk(position_o == 12, "R4 code3 rev", position_o, 12);
    do_reset();
    res_code_i = 12; pulse(1);
    chk(position_o == 384, "R5 code12 clamp", position_o, 384);
    res_code_i = 15; pulse(1);
    chk(position_o == 640, "R5 code15 clamp", position_o, 640);
  endtask

  task automatic t_dual();
    do_reset();
    pulse(1);
    chk(position_o == 1, "R7 single edge", position_o, 1);
    dual_edge_i = 1; pulse(2);
    chk(position_o == 5, "R7 dual edge", position_o, 5);
  endtask

  task automatic t_index();
    do_reset();
    pulse(1);
    chk(index_o == 0, "R9 first slot left", index_o, 0);
    res_code_i = 8; pulse(1);
    chk(index_o == 0, "R9 at 384", index_o, 0);
    dir_i = 1; pulse(1);
    chk(position_o == 128 && index_o == 1, "R9 back at 128", index_o, 1);
    do_reset();
    idx_step_mode_i = 1; pulse(1);
    chk(index_o == 1, "R9 monitor toggle 1", index_o, 1);
    pulse(1);
    chk(index_o == 0, "R9 monitor toggle 2", index_o, 0);
  endtask

  task automatic vel_window(input logic [23:0] v);
    velocity_i = v;
    for (int i = 0; i < 40; i++) begin
      if (i == 5 || i == 20) step_i = 1'b1;
      if (i == 15 || i == 28) step_i = 1'b0;
      @(negedge clk);
    end
    velocity_i = '0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_velocity();
    do_reset();
    vel_window(24'h400000);
    chk(position_o == 10, "R8 positive velocity", position_o, 10);
    do_reset();
    vel_window(24'hC00000);
    chk(position_o == 1014, "R8 negative velocity", position_o, 1014);
    do_reset();
    dir_inv_i = 1; vel_window(24'h400000);
    chk(position_o == 1014, "R8 velocity inverted", position_o, 1014);
    dir_inv_i = 0; pulse(1);
    chk(position_o == 1015, "R8 external resumes", position_o, 1015);
  endtask

  initial begin
    t_reset();
    t_fine();
    t_invert();
    t_coarse();
    t_dual();
    t_index();
    t_velocity();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule